// File: doc/BRIEF.md
# Paged Address Translation Unit

This block maps an 18-bit virtual word address to a physical word address. It reads one page-table word from main memory for each lookup. The upper 9 address bits are the page number and the lower 9 bits are the offset within the page. Each 36-bit table word holds the entries for two adjacent pages. A request carries:

- the virtual address;
- the user/exec mode;
- the current public-mode flag;
- whether the access is an instruction fetch;
- whether it is a write;
- whether it runs in the current context.

The user base, the exec base and the paging enable are sampled together with the request.

For a paged lookup the unit issues one read on a synchronous memory port, whose data returns one cycle later. It then checks the selected half-entry for access, write permission and public protection, and returns either a physical address or a fault. The fault comes with a fault-data word that describes the page, the mode and the reason. Exec pages are handled in three ways. Pages below 0340 (octal) bypass translation. Pages 0340–0377 are redirected into the user table. Pages 0400–0777 use the exec table.

Top module: `page_xlate_unit`

## Requirements
- R1: With paging disabled at accept, no memory read is issued, `done` pulses in the cycle after accept, `pa` equals the zero-extended virtual address, `pa_valid` is 1 and no fault is raised.
- R2: A successful translation gives `pa` = (half-entry bits 12:0) shifted left by 9, OR the 9-bit offset (VA bits 8:0).
- R3: In user mode the table word address is user base + (page >> 1). An even page uses word bits 35:18, and an odd page uses bits 17:0.
- R4: In exec mode, pages 0400–0777 read at exec base + (page >> 1), with the same half selection by page parity.
- R5: In exec mode, pages 0340–0377 read at user base + ((page + 0440) >> 1), that is, user-table word offsets 0400–0417.
- R6: In exec mode with paging on, pages 0–0337 map directly, exactly as in R1, with no read.
- R7: If half-entry bit 17 (access) is 0, `fault_page` is raised with `fault_data` = page<<18 | user<<27 | 010 (octal), and `pa_valid` is 0.
- R8: A write to an accessible entry whose bit 15 (writable) is 0 raises `fault_page` with code 011 in `fault_data` bits 5:0, and `pa_valid` is 0.
- R9: If public mode is active on a non-fetch access to an accessible, permitted entry whose bit 16 (public) is 0, `fault_public` is raised with `fault_data` = page<<18 | user<<27 | 021, and `pa_valid` is 0.
- R10: `public_set` is 1 when the current-context input was set, the entry is accessible and its bit 16 is 1. Otherwise it is 0, and it is always 0 for direct mappings.
- R11: A paged lookup holds `mem_rd_en` for exactly the accept cycle. `done` is a single-cycle pulse two cycles after accept. `req_ready` is low while busy, and the results hold until the next accept.
- R12: Fault priority is access, then write protection, then public violation. At most one fault flag is set, and `fault_data` is 0 when no fault occurs.
- R13: After reset, `req_ready` is 1 and `done`, `pa_valid`, both fault flags and `mem_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request, taken when `req_ready` is 1 |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_va | input | 18 | Virtual word address |
| req_user | input | 1 | 1 = user mode, 0 = exec mode |
| req_public | input | 1 | Public mode currently active |
| req_fetch | input | 1 | Access is an instruction fetch (exempt from the public check) |
| req_write | input | 1 | Access is a write |
| req_ctx | input | 1 | Access runs in the current context |
| paging_en | input | 1 | Translation enabled |
| user_base | input | MA_W | User page-table base word address |
| exec_base | input | MA_W | Exec page-table base word address |
| mem_rd_en | output | 1 | Table read request |
| mem_rd_addr | output | MA_W | Table word address |
| mem_rd_data | input | 36 | Table word, valid the cycle after `mem_rd_en` |
| done | output | 1 | One-cycle completion pulse |
| pa | output | 22 | Physical word address |
| pa_valid | output | 1 | `pa` is a valid translation |
| fault_page | output | 1 | Page fail (not accessible or write-protected) |
| fault_public | output | 1 | Public-protection violation |
| fault_data | output | 36 | Fault descriptor, 0 when no fault |
| public_set | output | 1 | Public flag to be set by the caller |

## Verification
The assertions assume two things about the memory port. It is synchronous, so `mem_rd_data` belongs to the address of the previous cycle. The unit's inputs are only meaningful in the cycle where `req_valid` meets `req_ready`. The bench models the memory as a registered read of a computed word pattern. It raises `req_valid` for one cycle only while the unit is idle, and never changes the bases or the enable mid-lookup. The sweep covers every page in both modes, so all three exec regions, both halves and every fault reason appear.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
    localparam int VA_W   = 18;
    localparam int PG_W   = 9;
    localparam int OFF_W  = VA_W - PG_W;
    localparam int PPN_W  = 13;
    localparam int HALF_W = 18;
    localparam int WORD_W = 2 * HALF_W;
    localparam int PA_W   = PPN_W + OFF_W;

    localparam int BIT_ACC = 17;
    localparam int BIT_PUB = 16;
    localparam int BIT_WR  = 15;

    localparam logic [5:0] CODE_NOACC = 6'o10;
    localparam logic [5:0] CODE_WPROT = 6'o11;
    localparam logic [5:0] CODE_PUBV  = 6'o21;

    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_DONE} ptu_state_e;

    typedef struct packed {
        logic [PA_W-1:0]   pa;
        logic              pa_valid;
        logic              f_page;
        logic              f_pub;
        logic              pub_set;
        logic [WORD_W-1:0] fdata;
    } ptu_result_t;
endpackage

// File: rtl/ptu_route.sv
module ptu_route
    import ptu_pkg::*;
#(
    parameter int         MA_W    = 22,
    parameter logic [8:0] WIN_LO  = 9'o340,
    parameter logic [8:0] WIN_HI  = 9'o377,
    parameter logic [8:0] EXEC_HI = 9'o400
) (
    input  logic [PG_W-1:0] page,
    input  logic            user,
    input  logic            paging_en,
    input  logic [MA_W-1:0] ubr,
    input  logic [MA_W-1:0] ebr,
    output logic            direct,
    output logic            odd,
    output logic [MA_W-1:0] tbl_addr
);
    localparam int IDX_W = PG_W + 1;
    localparam logic [IDX_W-1:0] WIN_SHIFT = IDX_W'(10'o1000) - IDX_W'(WIN_LO);

    logic [IDX_W-1:0] idx;
    logic [MA_W-1:0]  base;

    always_comb begin
        direct = 1'b0;
        idx    = {1'b0, page};
        base   = ubr;
        if (!paging_en) begin
            direct = 1'b1;
        end else if (user) begin
            base = ubr;
        end else if (page >= EXEC_HI) begin
            base = ebr;
        end else if (page >= WIN_LO && page <= WIN_HI) begin
            base = ubr;
            idx  = {1'b0, page} + WIN_SHIFT;
        end else begin
            direct = 1'b1;
        end
        odd      = idx[0];
        tbl_addr = base + MA_W'(idx >> 1);
    end
endmodule

// File: rtl/ptu_entry_chk.sv
module ptu_entry_chk
    import ptu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              odd,
    input  logic [PG_W-1:0]   page,
    input  logic [OFF_W-1:0]  off,
    input  logic              user,
    input  logic              wr,
    input  logic              pub_mode,
    input  logic              fetch,
    input  logic              ctx,
    output ptu_result_t       res
);
    logic [HALF_W-1:0] half;
    logic [WORD_W-1:0] fbase;
    logic acc, pbit, wbit;

    always_comb begin
        half  = odd ? word[HALF_W-1:0] : word[WORD_W-1:HALF_W];
        acc   = half[BIT_ACC];
        pbit  = half[BIT_PUB];
        wbit  = half[BIT_WR];
        fbase = (WORD_W'(page) << 18) | (WORD_W'(user) << 27);

        res          = '0;
        res.pa       = {half[PPN_W-1:0], off};
        res.pub_set  = ctx && acc && pbit;
        if (!acc) begin
            res.f_page = 1'b1;
            res.fdata  = fbase | WORD_W'(CODE_NOACC);
        end else if (wr && !wbit) begin
            res.f_page = 1'b1;
            res.fdata  = fbase | WORD_W'(CODE_WPROT);
        end else if (pub_mode && !fetch && !pbit) begin
            res.f_pub  = 1'b1;
            res.fdata  = fbase | WORD_W'(CODE_PUBV);
        end else begin
            res.pa_valid = 1'b1;
        end
    end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
    import ptu_pkg::*;
#(
    parameter int MA_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_user,
    input  logic              req_public,
    input  logic              req_fetch,
    input  logic              req_write,
    input  logic              req_ctx,
    input  logic              paging_en,
    input  logic [MA_W-1:0]   user_base,
    input  logic [MA_W-1:0]   exec_base,
    output logic              mem_rd_en,
    output logic [MA_W-1:0]   mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              done,
    output logic [PA_W-1:0]   pa,
    output logic              pa_valid,
    output logic              fault_page,
    output logic              fault_public,
    output logic [WORD_W-1:0] fault_data,
    output logic              public_set
);
    typedef struct packed {
        ptu_state_e       st;
        logic [PG_W-1:0]  page;
        logic [OFF_W-1:0] off;
        logic             user;
        logic             pub;
        logic             fetch;
        logic             wr;
        logic             ctx;
        logic             odd;
        ptu_result_t      res;
    } ctl_t;

    ctl_t        s_d, s_q;
    logic        rt_direct, rt_odd;
    logic [MA_W-1:0] rt_addr;
    ptu_result_t chk_res;

    ptu_route #(.MA_W(MA_W)) u_route (
        .page      (req_va[VA_W-1:OFF_W]),
        .user      (req_user),
        .paging_en (paging_en),
        .ubr       (user_base),
        .ebr       (exec_base),
        .direct    (rt_direct),
        .odd       (rt_odd),
        .tbl_addr  (rt_addr)
    );

    ptu_entry_chk u_chk (
        .word     (mem_rd_data),
        .odd      (s_q.odd),
        .page     (s_q.page),
        .off      (s_q.off),
        .user     (s_q.user),
        .wr       (s_q.wr),
        .pub_mode (s_q.pub),
        .fetch    (s_q.fetch),
        .ctx      (s_q.ctx),
        .res      (chk_res)
    );

    always_comb begin
        s_d         = s_q;
        mem_rd_en   = 1'b0;
        mem_rd_addr = rt_addr;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.page  = req_va[VA_W-1:OFF_W];
                    s_d.off   = req_va[OFF_W-1:0];
                    s_d.user  = req_user;
                    s_d.pub   = req_public;
                    s_d.fetch = req_fetch;
                    s_d.wr    = req_write;
                    s_d.ctx   = req_ctx;
                    s_d.odd   = rt_odd;
                    s_d.res   = '0;
                    if (rt_direct) begin
                        s_d.res.pa       = PA_W'(req_va);
                        s_d.res.pa_valid = 1'b1;
                        s_d.st           = ST_DONE;
                    end else begin
                        mem_rd_en = 1'b1;
                        s_d.st    = ST_READ;
                    end
                end
            end
            ST_READ: begin
                s_d.res = chk_res;
                s_d.st  = ST_DONE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready    = (s_q.st == ST_IDLE);
    assign done         = (s_q.st == ST_DONE);
    assign pa           = s_q.res.pa;
    assign pa_valid     = s_q.res.pa_valid;
    assign fault_page   = s_q.res.f_page;
    assign fault_public = s_q.res.f_pub;
    assign fault_data   = s_q.res.fdata;
    assign public_set   = s_q.res.pub_set;

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en); // R11
    AST_RD_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 done); // R11
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !req_ready); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_FAULT_BLOCKS_PA: assert property (@(posedge clk) disable iff (!rst_n)
        done && (fault_page || fault_public) |-> !pa_valid); // R7
    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0({fault_page, fault_public})); // R12
    AST_DIRECT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !paging_en |=> done && pa_valid && !fault_page && !fault_public); // R1
    AST_PUB_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault_public |-> fault_data[5:0] == 6'o21); // R9
endmodule

// File: tb/page_xlate_unit_bench.sv
module page_xlate_unit_bench;
    localparam int MA_W = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic req_valid = 0, req_user = 0, req_public = 0, req_fetch = 0, req_write = 0, req_ctx = 0;
    logic paging_en = 0;
    logic [17:0] req_va = '0;
    logic [MA_W-1:0] user_base = 22'h01200, exec_base = 22'h03400;
    logic req_ready, mem_rd_en, done, pa_valid, fault_page, fault_public, public_set;
    logic [MA_W-1:0] mem_rd_addr;
    logic [35:0] mem_rd_data, fault_data;
    logic [21:0] pa;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    page_xlate_unit #(.MA_W(MA_W)) u_page_xlate_unit (
        .clk, .rst_n, .req_valid, .req_ready, .req_va, .req_user, .req_public,
        .req_fetch, .req_write, .req_ctx, .paging_en, .user_base, .exec_base,
        .mem_rd_en, .mem_rd_addr, .mem_rd_data, .done, .pa, .pa_valid,
        .fault_page, .fault_public, .fault_data, .public_set
    );

    function automatic logic [17:0] half_at(logic [MA_W-1:0] a, int s);
        logic [31:0] h;
        h = 32'(a) * 37 + 32'(s) * 11 + (32'(a) >> 3);
        half_at = {(h % 7) != 0, h[1], h[2], h[4:3], 13'((32'(a) * 5 + 32'(s) * 3) & 32'h1fff)};
    endfunction

    function automatic logic [35:0] word_at(logic [MA_W-1:0] a);
        word_at = {half_at(a, 0), half_at(a, 1)};
    endfunction

    always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= word_at(mem_rd_addr);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(logic [17:0] va, logic usr, logic pub, logic fet, logic wr, logic ctx, logic pen);
        logic [8:0] page;
        logic [9:0] idx;
        logic [MA_W-1:0] base, e_addr;
        logic [17:0] half;
        logic direct, e_pav, e_fp, e_fq, e_ps;
        logic [35:0] e_fd, fb;
        logic [21:0] e_pa;
        logic seen_rd;
        logic [MA_W-1:0] seen_addr;
        int lat;
        page = va[17:9];
        idx = {1'b0, page};
        base = user_base;
        direct = !pen || (!usr && page < 9'o340);
        if (!usr && page >= 9'o400) base = exec_base;
        else if (!usr && page >= 9'o340) idx = {1'b0, page} + 10'o440;
        e_addr = base + MA_W'(idx >> 1);
        half = idx[0] ? word_at(e_addr)[17:0] : word_at(e_addr)[35:18];
        fb = (36'(page) << 18) | (36'(usr) << 27);
        e_pa = {half[12:0], va[8:0]}; e_pav = 0; e_fp = 0; e_fq = 0; e_fd = 0;
        e_ps = ctx && half[17] && half[16];
        if (direct) begin
            e_pa = 22'(va); e_pav = 1; e_ps = 0;
        end else if (!half[17]) begin e_fp = 1; e_fd = fb | 36'o10; end
        else if (wr && !half[15]) begin e_fp = 1; e_fd = fb | 36'o11; end
        else if (pub && !fet && !half[16]) begin e_fq = 1; e_fd = fb | 36'o21; end
        else e_pav = 1;

        @(negedge clk);
        req_va = va; req_user = usr; req_public = pub; req_fetch = fet;
        req_write = wr; req_ctx = ctx; paging_en = pen; req_valid = 1;
        #1;
        seen_rd = mem_rd_en; seen_addr = mem_rd_addr;
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        if (!direct) chk("R11 ready low while busy", req_ready, 0);
        while (!done && lat < 8) begin @(negedge clk); lat++; end
        chk(direct ? (pen ? "R6 no read" : "R1 no read") : "R3/R4/R5 read issued", seen_rd, !direct);
        if (!direct) chk(usr ? "R3 table addr" : (page >= 9'o400 ? "R4 exec addr" : "R5 redirect addr"), seen_addr, e_addr);
        chk("R11 latency", lat, direct ? 1 : 2);
        chk("R2 pa_valid", pa_valid, e_pav);
        if (e_pav) chk(direct ? "R1 R6 direct pa" : "R2 pa", pa, e_pa);
        chk("R7 R8 fault_page", fault_page, e_fp);
        chk("R9 fault_public", fault_public, e_fq);
        chk("R12 fault_data", fault_data, e_fd);
        chk("R10 public_set", public_set, e_ps);
        @(negedge clk);
        chk("R11 done single pulse", done, 0);
        chk("R11 result held", pa_valid, e_pav);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R13 ready", req_ready, 1);
        chk("R13 done", done, 0);
        chk("R13 pa_valid", pa_valid, 0);
        chk("R13 faults", {fault_page, fault_public}, 0);
        chk("R13 rd_en", mem_rd_en, 0);
        rst_n = 1;
        for (int i = 0; i < 16; i++)
            run(18'(i * 16411 + 5), i[0], 1'b1, 1'b0, i[1], 1'b1, 1'b0);
        for (int u = 0; u < 2; u++)
            for (int p = 0; p < 512; p++) begin
                logic [8:0] pg = 9'(p);
                run({pg, 9'((p * 7 + u * 3) & 511)}, u[0], pg[1] ^ u[0], pg[2],
                    pg[3] ^ pg[5], pg[4], 1'b1);
            end
        finished = 1;
    end

    initial begin
        while (!finished && cyc < 150000) begin @(posedge clk); cyc++; end
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule